// File: doc/BRIEF.md
# Single-Precision Float to S15.16 Fixed-Point Converter

This block turns a 32-bit binary floating-point word into a 32-bit two's-complement fixed-point number with 16 fraction bits, rounding to nearest with ties going to the even value. It takes the float word with a valid strobe. It returns the fixed word, a valid strobe and an overflow flag. The overflow flag goes high whenever the result had to be saturated.

The input word is first sorted into one of four classes, and the class drives the output selection. `CLS_ZERO` covers a zero exponent field, so zeros and subnormals both give 0. `CLS_NUM` covers finite normal values. `CLS_INF` and `CLS_NAN` cover the all-ones exponent field. A finite value has its significand shifted left or right. The shift count is the unbiased exponent less 7, clamped to the range -31..+31. Right shifts are then rounded from the round bit and the sticky bit. The magnitude is range-checked, and negative values are then negated.

Two parameters set the build. `REG_OUT` selects either a purely combinational path or one output register. `ALT_RND` selects the increment-then-clear-LSB form of the rounding logic in place of the direct form.

Top module: `f32_to_sfix`

## Requirements
- R1: The input word splits into sign (bit 31), an 8-bit exponent (bits 30:23, bias 127) and a 23-bit fraction (bits 22:0). The significand is the fraction with a leading 1 above it. For example, 0x3F800000 (1.0) gives 0x00010000 and 0x40400000 (3.0) gives 0x00030000.
- R2: An exponent field of 0 gives an output of 0 with the overflow flag low. This holds for +0, -0 and every subnormal.
- R3: When the shift count is negative, the result is round-half-even of x·65536. The round bit is the highest discarded bit and the sticky bit is the OR of the lower discarded bits. For example, 2^-17 gives 0, 1.5·2^-16 gives 2 and 2.5·2^-16 gives 2.
- R4: When the shift count is zero or positive, the result is exact and no rounding is applied. For example, 12345.0 gives 0x30390000.
- R5: The shift count is clamped to -31..+31. Very small magnitudes give 0, and large exponents saturate.
- R6: The alternate rounding form (`ALT_RND=1`) gives results identical to the direct form for every input.
- R7: For an input with the sign bit set, the output is the two's-complement negation of the rounded magnitude. For example, -1.0 gives 0xFFFF0000.
- R8: When the rounded magnitude exceeds 0x7FFFFFFF for a positive value, the output is 0x7FFFFFFF with the overflow flag high. When it exceeds 0x80000000 for a negative value, the output is 0x80000000 with the overflow flag high. Infinities saturate by their sign, and every NaN (exponent 255 with a nonzero fraction) saturates to 0x7FFFFFFF. An input of exactly -32768.0 gives 0x80000000 with no overflow, while +32768.0 overflows.
- R9: With `REG_OUT=1`, the output valid follows the input valid exactly one cycle later, and the data and flag come with it. With `REG_OUT=0`, the outputs follow the inputs in the same cycle.
- R10: While reset is held, the registered outputs are valid low, data 0 and overflow low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_in | input | 32 | Floating-point input word |
| flt_valid | input | 1 | Input word is valid |
| fix_out | output | 32 | S15.16 two's-complement result |
| fix_valid | output | 1 | Result is valid |
| fix_ovf | output | 1 | Result was saturated |

## Verification
The assertions check several properties on every cycle:
- a zero exponent field always yields zero with no overflow;
- a raised overflow flag always comes with one of the two saturation codes;
- a nonzero unsaturated result carries the input's sign;
- a NaN always saturates positive;
- the output valid trails the input valid by one cycle in the registered build.

The assertions cannot show the numeric value itself. The bench scenarios cover that against an independent remainder-based model: tie breaking toward even, exact left shifts, clamping at both ends, the -32768 boundary, and the equivalence of the two rounding forms checked against a second, combinational instance.

// File: rtl/f2x_pkg.sv
package f2x_pkg;
    // Class of an incoming float word; drives the output selection.
    typedef enum logic [1:0] {
        CLS_ZERO,   // exponent field zero: zero or subnormal, flushed
        CLS_NUM,    // finite normal value
        CLS_INF,    // exponent all ones, fraction zero
        CLS_NAN     // exponent all ones, fraction nonzero
    } f2x_cls_e;
endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack #(
    parameter int EXP_W    = 8,
    parameter int FRAC_W   = 23,
    parameter int OUT_FRAC = 16,
    parameter int SH_LIM   = 31,
    parameter int SH_W     = 6
) (
    input  logic [EXP_W+FRAC_W:0]  flt,
    output logic                   sign,
    output f2x_pkg::f2x_cls_e      cls,
    output logic [FRAC_W:0]        sig,
    output logic signed [SH_W-1:0] shamt
);
    import f2x_pkg::*;

    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int SHIFT_OFS = BIAS + FRAC_W - OUT_FRAC;
    localparam int RAW_W     = EXP_W + 2;

    logic [EXP_W-1:0]        expf;
    logic [FRAC_W-1:0]       frac;
    logic signed [RAW_W-1:0] raw;
    logic signed [RAW_W-1:0] clamped;

    assign sign = flt[EXP_W+FRAC_W];
    assign expf = flt[EXP_W+FRAC_W-1:FRAC_W];
    assign frac = flt[FRAC_W-1:0];

    always_comb begin
        if (expf == '0)
            cls = CLS_ZERO;
        else if (expf == '1)
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NUM;
    end

    // Hidden one only for normal values; zero-class significand is zero.
    assign sig = (expf == '0) ? '0 : {1'b1, frac};

    assign raw = $signed({2'b00, expf}) - $signed(RAW_W'(SHIFT_OFS));

    always_comb begin
        if (raw > $signed(RAW_W'(SH_LIM)))
            clamped = $signed(RAW_W'(SH_LIM));
        else if (raw < -$signed(RAW_W'(SH_LIM)))
            clamped = -$signed(RAW_W'(SH_LIM));
        else
            clamped = raw;
    end

    assign shamt = clamped[SH_W-1:0];
endmodule

// File: rtl/f2x_shift_round.sv
module f2x_shift_round #(
    parameter int SIG_W   = 24,
    parameter int SH_LIM  = 31,
    parameter int SH_W    = 6,
    parameter bit ALT_RND = 1'b0,
    parameter int MAG_W   = SIG_W + SH_LIM
) (
    input  logic [SIG_W-1:0]       sig,
    input  logic signed [SH_W-1:0] shamt,
    output logic [MAG_W-1:0]       mag
);
    localparam int EXT_W = SIG_W + SH_LIM;

    logic              go_right;
    logic [SH_W-1:0]   neg_amt;
    logic [SH_W-2:0]   lsh;
    logic [SH_W-2:0]   rsh;
    logic [EXT_W-1:0]  ext;
    logic [SIG_W-1:0]  trunc;
    logic              rnd_bit;
    logic              stk_bit;
    logic [SIG_W:0]    rounded;

    assign go_right = shamt[SH_W-1];
    assign neg_amt  = -shamt;
    assign lsh      = go_right ? '0 : shamt[SH_W-2:0];
    assign rsh      = go_right ? neg_amt[SH_W-2:0] : '0;

    // Discarded bits land in the low SH_LIM positions of ext.
    assign ext     = {sig, {SH_LIM{1'b0}}} >> rsh;
    assign trunc   = ext[EXT_W-1:SH_LIM];
    assign rnd_bit = ext[SH_LIM-1];
    assign stk_bit = |ext[SH_LIM-2:0];

    generate
        if (ALT_RND) begin : g_rnd_alt
            logic [SIG_W:0] bumped;
            assign bumped  = {1'b0, trunc} + {{SIG_W{1'b0}}, rnd_bit};
            assign rounded = (rnd_bit && !stk_bit) ? {bumped[SIG_W:1], 1'b0} : bumped;
        end else begin : g_rnd_lit
            logic inc;
            assign inc     = rnd_bit & (stk_bit | trunc[0]);
            assign rounded = {1'b0, trunc} + {{SIG_W{1'b0}}, inc};
        end
    endgenerate

    assign mag = go_right ? MAG_W'(rounded) : (MAG_W'(sig) << lsh);
endmodule

// File: rtl/f2x_pack.sv
module f2x_pack #(
    parameter int OUT_W = 32,
    parameter int MAG_W = 55
) (
    input  logic              sign,
    input  f2x_pkg::f2x_cls_e cls,
    input  logic [MAG_W-1:0]  mag,
    output logic [OUT_W-1:0]  data,
    output logic              ovf
);
    import f2x_pkg::*;

    localparam logic [OUT_W-1:0] SAT_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] SAT_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic big;
    logic too_pos;
    logic too_neg;

    assign big     = |mag[MAG_W-1:OUT_W];
    assign too_pos = big | mag[OUT_W-1];
    assign too_neg = big | (mag[OUT_W-1] & (|mag[OUT_W-2:0]));

    always_comb begin
        data = '0;
        ovf  = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                data = '0;
                ovf  = 1'b0;
            end
            CLS_NUM: begin
                if (sign ? too_neg : too_pos) begin
                    data = sign ? SAT_NEG : SAT_POS;
                    ovf  = 1'b1;
                end else begin
                    data = sign ? -mag[OUT_W-1:0] : mag[OUT_W-1:0];
                end
            end
            CLS_INF: begin
                data = sign ? SAT_NEG : SAT_POS;
                ovf  = 1'b1;
            end
            CLS_NAN: begin
                data = SAT_POS;
                ovf  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/f32_to_sfix.sv
module f32_to_sfix #(
    parameter bit REG_OUT  = 1'b1,
    parameter bit ALT_RND  = 1'b0,
    parameter int EXP_W    = 8,
    parameter int FRAC_W   = 23,
    parameter int OUT_W    = 32,
    parameter int OUT_FRAC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [EXP_W+FRAC_W:0]   flt_in,
    input  logic                    flt_valid,
    output logic [OUT_W-1:0]        fix_out,
    output logic                    fix_valid,
    output logic                    fix_ovf
);
    import f2x_pkg::*;

    localparam int SIG_W  = FRAC_W + 1;
    localparam int SH_LIM = OUT_W - 1;
    localparam int SH_W   = $clog2(SH_LIM + 1) + 1;
    localparam int MAG_W  = SIG_W + SH_LIM;

    logic                   u_sign;
    f2x_cls_e               u_cls;
    logic [SIG_W-1:0]       u_sig;
    logic signed [SH_W-1:0] u_shamt;
    logic [MAG_W-1:0]       u_mag;
    logic [OUT_W-1:0]       nxt_data;
    logic                   nxt_ovf;

    f2x_unpack #(
        .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_FRAC(OUT_FRAC),
        .SH_LIM(SH_LIM), .SH_W(SH_W)
    ) unpack_i (
        .flt(flt_in), .sign(u_sign), .cls(u_cls), .sig(u_sig), .shamt(u_shamt)
    );

    f2x_shift_round #(
        .SIG_W(SIG_W), .SH_LIM(SH_LIM), .SH_W(SH_W), .ALT_RND(ALT_RND), .MAG_W(MAG_W)
    ) shround_i (
        .sig(u_sig), .shamt(u_shamt), .mag(u_mag)
    );

    f2x_pack #(
        .OUT_W(OUT_W), .MAG_W(MAG_W)
    ) pack_i (
        .sign(u_sign), .cls(u_cls), .mag(u_mag), .data(nxt_data), .ovf(nxt_ovf)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [OUT_W-1:0] data_q;
            logic             ovf_q;
            logic             vld_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    ovf_q  <= 1'b0;
                    vld_q  <= 1'b0;
                end else begin
                    vld_q <= flt_valid;
                    if (flt_valid) begin
                        data_q <= nxt_data;
                        ovf_q  <= nxt_ovf;
                    end
                end
            end

            assign fix_out   = data_q;
            assign fix_ovf   = ovf_q;
            assign fix_valid = vld_q;

            assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
                flt_valid |=> fix_valid);
            assert_idle_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !flt_valid |=> !fix_valid);
        end else begin : g_comb
            assign fix_out   = nxt_data;
            assign fix_ovf   = nxt_ovf;
            assign fix_valid = flt_valid;
        end
    endgenerate

    assert_zero_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_in[EXP_W+FRAC_W-1:FRAC_W] == '0) |-> (nxt_data == '0 && !nxt_ovf));

    assert_sat_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_ovf |-> (nxt_data == {1'b0, {(OUT_W-1){1'b1}}} ||
                     nxt_data == {1'b1, {(OUT_W-1){1'b0}}}));

    assert_nan_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_in[EXP_W+FRAC_W-1:FRAC_W] == '1 && flt_in[FRAC_W-1:0] != '0)
        |-> (nxt_ovf && !nxt_data[OUT_W-1]));

    assert_sign_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nxt_ovf && nxt_data != '0) |-> (nxt_data[OUT_W-1] == flt_in[EXP_W+FRAC_W]));
endmodule

// File: tb/f32_to_sfix_tb_top.sv
`timescale 1ns/1ps
module f32_to_sfix_tb_top;
    typedef struct {
        logic [31:0] data;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] flt_in = '0;
    logic        flt_valid = 1'b0;
    logic [31:0] fix_out, alt_out;
    logic        fix_valid, fix_ovf, alt_valid, alt_ovf;

    int n_chk = 0;
    int n_fail = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    f32_to_sfix dut_i (
        .clk(clk), .rst_n(rst_n), .flt_in(flt_in), .flt_valid(flt_valid),
        .fix_out(fix_out), .fix_valid(fix_valid), .fix_ovf(fix_ovf)
    );

    // Combinational build with the alternate rounding form.
    f32_to_sfix #(.REG_OUT(1'b0), .ALT_RND(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .flt_in(flt_in), .flt_valid(flt_valid),
        .fix_out(alt_out), .fix_valid(alt_valid), .fix_ovf(alt_ovf)
    );

    task automatic check(input bit ok, input string tag, input logic [32:0] act,
                         input logic [32:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual ovf=%0b data=%08h expected ovf=%0b data=%08h",
                     tag, act[32], act[31:0], expv[32], expv[31:0]);
        end
    endtask

    // Independent model: remainder-based round-half-even of x*65536.
    function automatic logic [32:0] model(input logic [31:0] w);
        logic        sgn = w[31];
        int          e = int'(w[30:23]);
        longint      sig, q, r, half, mag, lim;
        int          k, n;
        bit          ovf = 0;
        if (e == 255)
            return (w[22:0] != 0 || !sgn) ? {1'b1, 32'h7FFFFFFF} : {1'b1, 32'h80000000};
        if (e == 0) return '0;
        sig = longint'({1'b1, w[22:0]});
        k = e - 134;
        mag = 0;
        if (k > 8) ovf = 1;
        else if (k >= 0) mag = sig << k;
        else begin
            n = -k;
            if (n <= 40) begin
                q = sig >> n;
                r = sig - (q << n);
                half = 64'sd1 << (n - 1);
                if (r > half || (r == half && q[0])) q = q + 1;
                mag = q;
            end
        end
        lim = sgn ? 64'sd2147483648 : 64'sd2147483647;
        if (ovf || mag > lim) return sgn ? {1'b1, 32'h80000000} : {1'b1, 32'h7FFFFFFF};
        return {1'b0, sgn ? 32'(-mag) : 32'(mag)};
    endfunction

    task automatic drive(input logic [31:0] w, input string tag);
        logic [32:0] e;
        exp_t it;
        e = model(w);
        @(negedge clk);
        flt_in = w;
        flt_valid = 1'b1;
        it.data = e[31:0];
        it.ovf = e[32];
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        // R6 / R9: alternate-rounding combinational build, same cycle
        check({alt_ovf, alt_out} == e && alt_valid, {tag, " R6 R9 comb/alt"},
              {alt_ovf, alt_out}, e);
    endtask

    task automatic idle_check();
        @(negedge clk);
        flt_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        check(!fix_valid && sb_q.size() == 0, "R9 idle valid", {1'b0, 31'b0, fix_valid}, '0);
    endtask

    // Monitor: compares registered results against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && fix_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected valid", {fix_ovf, fix_out}, '0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check({fix_ovf, fix_out} == {it.ovf, it.data}, it.tag,
                          {fix_ovf, fix_out}, {it.ovf, it.data});
                end
            end
        end
    end

    initial begin
        #(10 * 150000);
        check(1'b0, "watchdog", '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check(!fix_valid && fix_out == 0 && !fix_ovf, "R10 reset",
              {fix_ovf, fix_out}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'h3F800000, "R1 1.0");
        check(model(32'h3F800000) == 33'h000010000, "R1 model 1.0", model(32'h3F800000), 33'h000010000);
        drive(32'h40400000, "R1 3.0");
        drive(32'h3F8CCCCD, "R3 1.1");
        drive(32'h40066666, "R3 2.1");
        drive(32'h37000000, "R3 tie 0.5lsb to even 0");
        check(model(32'h37C00000) == 33'd2, "R3 model 1.5lsb", model(32'h37C00000), 33'd2);
        drive(32'h37C00000, "R3 tie 1.5lsb to 2");
        drive(32'h38200000, "R3 tie 2.5lsb to 2");
        drive(32'h37000001, "R3 above tie");
        drive(32'h4640E400, "R4 12345.0");
        drive(32'h46FFFFFF, "R4 max finite below 2^15");
        drive(32'h0DA24260, "R5 tiny clamp");
        drive(32'h7F000000, "R5 R8 huge clamp");
        drive(32'hBF800000, "R7 -1.0");
        drive(32'hC0066666, "R7 -2.1");
        drive(32'h80000000, "R2 R7 -0");
        drive(32'h00000001, "R2 subnormal");
        drive(32'h807FFFFF, "R2 neg subnormal");
        drive(32'h47000000, "R8 +32768 overflow");
        drive(32'hC7000000, "R8 -32768 exact");
        drive(32'hC7000080, "R8 below -32768");
        drive(32'h7F800000, "R8 +inf");
        drive(32'hFF800000, "R8 -inf");
        drive(32'h7FC00000, "R8 NaN");
        drive(32'hFFC00001, "R8 neg NaN");
        idle_check();

        lf = 32'h1234ABCD;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            lf ^= lf << 13;
            lf ^= lf >> 17;
            lf ^= lf << 5;
            w = {lf[31], 8'(100 + (lf[30:23] % 46)), lf[22:0]};
            drive(w, "R3 R4 R7 sweep");
            if (i % 500 == 0) idle_check();
        end
        idle_check();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule